// File: doc/BRIEF.md
# Reorderable Two-Stage Pipeline Router

The router carries a stream of video samples through two processing stages, a filter stage and a matrix stage. A configuration word sets the order of the two stages at run time. It can also cut the chain after the first stage in the chosen order, so that the first stage's result goes straight to the output lookup section. Both stages are fixed-latency placeholders: a 35-cycle filter delay line and a 6-cycle matrix delay line. Each carries data and a valid flag. The block owns the interconnect multiplexing, the order selection and the alignment of the valid flag on every path.

When the chain is cut after the first stage, the skipped stage's delay leaves the path entirely. It is not replaced by a matching delay. The total latency therefore depends on both the order and the cut setting: 41 cycles with both stages in use, 35 cycles with the filter alone, and 6 cycles with the matrix alone.

A two-state controller guards the routing. In `RT_IDLE` no sample is in flight, and a shadow copy of the configuration follows the configuration word on every cycle without input. The transition `go_busy` fires when a valid sample enters, and the controller moves to `RT_BUSY`. In `RT_BUSY` the shadow is frozen. The transition `go_idle` fires when the in-flight count reaches zero and no new sample arrives. The transition `stay` covers every other cycle.

Top module: `stage_router`

## Requirements
- R1: While reset is low, and afterwards until a sample is sent, `out_valid` is 0. Reset empties both delay lines, so no stale sample ever appears.
- R2: With `cfg_word` bit 4 = 0 (filter feeds matrix) and bit 9 = 0, each sample reaches `out_data` unchanged, with `out_valid` high exactly 41 cycles after its `in_valid` cycle.
- R3: With bit 4 = 1 (matrix feeds filter) and bit 9 = 0, each sample appears unchanged exactly 41 cycles after input.
- R4: With bit 9 = 1 (first stage only) and bit 4 = 0, only the filter stage is used, and each sample appears unchanged exactly 35 cycles after input.
- R5: With bit 9 = 1 and bit 4 = 1, the matrix output is routed directly to the output, and each sample appears unchanged exactly 6 cycles after input.
- R6: The configuration is taken only while no sample is in flight. A change to `cfg_word` while samples are in flight does not alter the latency or routing of any sample sent before the pipeline empties.
- R7: `out_valid` is high only for a sample that was sent. A stage skipped in first-stage-only mode keeps nothing that could appear later under another setting.
- R8: Samples sent on consecutive cycles or with gaps come out in input order, each at the latency of the routing in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input sample valid |
| in_data | input | DATA_W (16) | Input sample |
| cfg_word | input | CFG_W (16) | Configuration word; bit 4 sets the order, bit 9 sets first-stage-only mode |
| out_valid | output | 1 | Output sample valid |
| out_data | output | DATA_W (16) | Routed output sample |

## Verification
The assertions assume that `cfg_word` changes take effect only through the shadow copy. They also assume that the in-flight count never exceeds the 41 cycles of samples the longest path can hold, so the pipeline drains and the controller returns to idle. The stimulus keeps each configuration stable for several idle cycles before a burst starts. It changes the word in the middle of a burst only in the dedicated case that checks the frozen routing. Every burst is fully drained before the next configuration is expected to apply.

// File: rtl/stage_route_pkg.sv
package stage_route_pkg;

    typedef enum logic [0:0] {
        RT_IDLE = 1'b0,
        RT_BUSY = 1'b1
    } rt_state_e;

    typedef struct packed {
        logic mat_first;
        logic first_only;
    } route_cfg_t;

endpackage

// File: rtl/stage_delay.sv
module stage_delay #(
    parameter int W     = 16,
    parameter int DEPTH = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int LAST = DEPTH - 1;

    logic [W-1:0] dat_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                dat_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= in_valid;
            dat_q[0] <= in_data;
            for (int i = 1; i < DEPTH; i++) begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    assign out_valid = vld_q[LAST];
    assign out_data  = dat_q[LAST];
endmodule

// File: rtl/route_ctrl.sv
module route_ctrl
    import stage_route_pkg::*;
#(
    parameter int CFG_W     = 16,
    parameter int ARR_BIT   = 4,
    parameter int FIRST_BIT = 9,
    parameter int CNT_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             out_valid,
    input  logic [CFG_W-1:0] cfg_word,
    output rt_state_e        state_q,
    output route_cfg_t       cfg_q,
    output logic [CNT_W-1:0] inflight_q
);
    rt_state_e        state_d;
    logic [CNT_W-1:0] inflight_d;

    always_comb begin
        inflight_d = inflight_q;
        if (in_valid && !out_valid) inflight_d = inflight_q + 1'b1;
        if (!in_valid && out_valid) inflight_d = inflight_q - 1'b1;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RT_IDLE: if (in_valid) state_d = RT_BUSY;
            RT_BUSY: if (inflight_d == '0 && !in_valid) state_d = RT_IDLE;
            default: state_d = RT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RT_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_d;
            if (state_q == RT_IDLE && !in_valid) begin
                cfg_q.mat_first  <= cfg_word[ARR_BIT];
                cfg_q.first_only <= cfg_word[FIRST_BIT];
            end
        end
    end
endmodule

// File: rtl/stage_router.sv
module stage_router
    import stage_route_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int CFG_W     = 16,
    parameter int FILT_LAT  = 35,
    parameter int MAT_LAT   = 6,
    parameter int ARR_BIT   = 4,
    parameter int FIRST_BIT = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic [CFG_W-1:0]  cfg_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int TOTAL = FILT_LAT + MAT_LAT;
    localparam int CNT_W = $clog2(TOTAL + 2);

    rt_state_e        rt_state;
    route_cfg_t       rt_cfg;
    logic [CNT_W-1:0] inflight;

    logic              filt_in_v, filt_v, mat_in_v, mat_v;
    logic [DATA_W-1:0] filt_in_d, filt_d, mat_in_d, mat_d;

    route_ctrl #(
        .CFG_W(CFG_W), .ARR_BIT(ARR_BIT), .FIRST_BIT(FIRST_BIT), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
        .cfg_word(cfg_word), .state_q(rt_state), .cfg_q(rt_cfg),
        .inflight_q(inflight)
    );

    always_comb begin
        if (rt_cfg.mat_first) begin
            mat_in_v  = in_valid;
            mat_in_d  = in_data;
            filt_in_v = mat_v && !rt_cfg.first_only;
            filt_in_d = mat_d;
        end else begin
            filt_in_v = in_valid;
            filt_in_d = in_data;
            mat_in_v  = filt_v && !rt_cfg.first_only;
            mat_in_d  = filt_d;
        end
    end

    stage_delay #(.W(DATA_W), .DEPTH(FILT_LAT)) u_filt (
        .clk(clk), .rst_n(rst_n), .in_valid(filt_in_v), .in_data(filt_in_d),
        .out_valid(filt_v), .out_data(filt_d)
    );

    stage_delay #(.W(DATA_W), .DEPTH(MAT_LAT)) u_mat (
        .clk(clk), .rst_n(rst_n), .in_valid(mat_in_v), .in_data(mat_in_d),
        .out_valid(mat_v), .out_data(mat_d)
    );

    always_comb begin
        unique case ({rt_cfg.first_only, rt_cfg.mat_first})
            2'b00, 2'b11: begin out_valid = mat_v;  out_data = mat_d;  end
            2'b01, 2'b10: begin out_valid = filt_v; out_data = filt_d; end
            default:      begin out_valid = 1'b0;   out_data = '0;     end
        endcase
    end
endmodule

// File: rtl/stage_router_chk.sv
module stage_router_chk
    import stage_route_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int TOTAL = 41
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             mat_v,
    input rt_state_e        rt_state,
    input route_cfg_t       rt_cfg,
    input logic [CNT_W-1:0] inflight
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inflight == '0) |-> !out_valid);

    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rt_state) == RT_BUSY) |-> $stable(rt_cfg));

    // R5
    mat_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && rt_cfg.first_only && rt_cfg.mat_first) |-> mat_v);

    // R8
    inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(TOTAL));
endmodule

bind stage_router stage_router_chk #(.CNT_W(CNT_W), .TOTAL(TOTAL)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .mat_v(mat_v),
    .rt_state(rt_state), .rt_cfg(rt_cfg), .inflight(inflight)
);

// File: tb/test_stage_router.sv
`timescale 1ns/1ps
module test_stage_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic [15:0] cfg_word = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [15:0] exp_d[$];
    int          exp_due[$];
    string       exp_tag[$];
    bit eff_mf = 1'b0;
    bit eff_fo = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    stage_router i_stage_router (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .cfg_word(cfg_word), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic int lat_of(bit mf, bit fo);
        if (fo) return mf ? 6 : 35;
        return 41;
    endfunction

    function automatic logic [15:0] mk_cfg(bit mf, bit fo);
        logic [15:0] w = 16'h0;
        w[4] = mf;
        w[9] = fo;
        return w;
    endfunction

    // monitor: pops expected items as results appear
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_d.size() == 0) begin
                failures++;
                $display("FAIL R7: spurious output data=%h at cycle %0d, expected none", out_data, cyc);
            end else begin
                automatic logic [15:0] d = exp_d.pop_front();
                automatic int due = exp_due.pop_front();
                automatic string tg = exp_tag.pop_front();
                if (d !== out_data || due != cyc) begin
                    failures++;
                    $display("FAIL %s: got data=%h cycle=%0d, expected data=%h cycle=%0d",
                             tg, out_data, cyc, d, due);
                end
            end
        end
    end

    task automatic set_cfg(bit mf, bit fo);
        cfg_word = mk_cfg(mf, fo);
        repeat (4) @(negedge clk);
        eff_mf = mf;
        eff_fo = fo;
    endtask

    task automatic send(logic [15:0] d, int gap, string tg);
        in_valid = 1'b1;
        in_data  = d;
        exp_d.push_back(d);
        exp_due.push_back(cyc + lat_of(eff_mf, eff_fo));
        exp_tag.push_back(tg);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain(string tg);
        int guard = 0;
        while (exp_d.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
        checks++;
        if (exp_d.size() != 0) begin
            failures++;
            $display("FAIL %s: %0d samples missing, expected 0", tg, exp_d.size());
        end
    endtask

    task automatic burst(bit mf, bit fo, logic [15:0] base, string tg);
        set_cfg(mf, fo);
        for (int i = 0; i < 6; i++) send(base + 16'(i * 37), i % 3, tg);
        for (int i = 0; i < 4; i++) send(base ^ 16'(16'h0f0f + i), 0, "R8");
        drain(tg);
    endtask

    initial begin
        @(negedge clk);
        repeat (4) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: out_valid=%b in reset, expected 0", out_valid);
        end
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1: out_valid=%b after reset, expected 0", out_valid);
        end

        burst(1'b0, 1'b0, 16'h1000, "R2");
        burst(1'b1, 1'b0, 16'h2345, "R3");
        burst(1'b0, 1'b1, 16'h3a5c, "R4");
        // R7: filter-only leaves matrix empty; switch to full order
        set_cfg(1'b0, 1'b0);
        repeat (60) @(negedge clk);
        burst(1'b1, 1'b1, 16'h4c01, "R5");
        set_cfg(1'b1, 1'b0);
        repeat (60) @(negedge clk);
        checks++;
        if (exp_d.size() != 0) begin
            failures++;
            $display("FAIL R7: queue=%0d, expected 0", exp_d.size());
        end

        // R6: change config mid-flight; earlier routing must hold
        set_cfg(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) send(16'h5a00 + 16'(i), 1, "R6");
        cfg_word = mk_cfg(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) send(16'h5b00 + 16'(i), 0, "R6");
        drain("R6");
        repeat (4) @(negedge clk);
        eff_mf = 1'b1;
        eff_fo = 1'b1;
        send(16'h6006, 0, "R5");
        drain("R5");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule